// File: doc/BRIEF.md
# SPI Descriptor Chain Sequencer

This block walks a linked run of transfer descriptors held in memory and feeds them one at a time to a serial transfer engine. Every descriptor is six 32-bit words laid out back to back:

- a start word, whose bit 30 marks the last descriptor of the run;
- a bus configuration word;
- a 64-bit transmit buffer address, low word first;
- a 64-bit receive buffer address, low word first.

The sequencer reads the six words over a simple request/response port. It presents them to the engine with a one-cycle start pulse, then waits for the engine's done pulse. If the descriptor was not the last one, it moves on to the descriptor 24 bytes further on. Because each descriptor carries its own full bus configuration, clock, lane and chip-select settings can differ from one descriptor to the next.

Software sets a 64-bit list pointer and starts the run by writing the upper pointer word with its top bit set. As an alternative, the run can start on a chosen edge of an external sync input. Writing zero to the upper pointer word during a run cancels it. A write-one-to-clear status register collects per-descriptor, end-of-run and fetch-error events, and a masked interrupt line is driven from it. A separate one-bit ownership flag lets software claim the block before use.

Register offsets: 0x00 ownership flag, 0x04 trigger configuration, 0x20/0x24 list pointer low/high, 0x28/0x2C current descriptor pointer low/high, 0x30 status, 0x34 interrupt enable.

Top module: `spi_desc_chain_seq`

## Requirements
- R1: After reset the ownership flag at 0x00 reads 1, status at 0x30 reads 0, irq is low, mem_req is low and no eng_start pulse occurs.
- R2: Writing 0x24 with bit 31 set while idle starts a run at {wdata[30:0], pointer low}. The six descriptor words are read one at a time at that address plus 0, 4, 8, 12, 16 and 20.
- R3: After the sixth word, eng_start pulses for exactly one cycle. At that point eng_cfg = word 0, eng_bus = word 1, eng_tx_addr = {word 3, word 2} and eng_rx_addr = {word 5, word 4}.
- R4: On eng_done for a descriptor whose start-word bit 30 is clear, the next descriptor is fetched 24 bytes further on. The current pointer at 0x28/0x2C reads the base address of the descriptor being executed.
- R5: On eng_done for a descriptor whose start-word bit 30 is set, the run stops. Status bit 11 (run done) and bit 9 (block free) are set, and bit 31 of 0x24 reads 0 again.
- R6: Every eng_done accepted during a run sets status bit 10 (descriptor done).
- R7: A fetch response with mem_rerr set stops the run without an eng_start pulse. It sets status bit 8 (descriptor error) and bit 9.
- R8: With bit 6 of 0x04 set, a rising edge on sync_in starts a run at the stored list pointer. With bit 7 set, a falling edge does the same. With both bits clear, sync_in has no effect.
- R9: Writing zero to 0x24 during a run cancels it. No further fetch or eng_start follows, a later eng_done is ignored, and no status bit is set.
- R10: Writing ones to status bits clears them. irq is high exactly when some status bit is set whose enable bit at 0x34 is also set.
- R11: Writing 0 to 0x00 makes it read 0, and writing 1 makes it read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| sync_in | input | 1 | External start trigger |
| mem_req | output | 1 | Descriptor word read request, held until response |
| mem_addr | output | 64 | Byte address of the requested word |
| mem_rvalid | input | 1 | Response valid for the current request |
| mem_rdata | input | 32 | Response data |
| mem_rerr | input | 1 | Response carries an error |
| eng_start | output | 1 | One-cycle start pulse to the transfer engine |
| eng_cfg | output | 32 | Start/config word of the current descriptor |
| eng_bus | output | 32 | Bus config word of the current descriptor |
| eng_tx_addr | output | 64 | Transmit buffer address |
| eng_rx_addr | output | 64 | Receive buffer address |
| eng_done | input | 1 | Engine finished the current descriptor |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest situation to reach is a cancel that lands while the engine is still busy with a descriptor. Only then does the done pulse that follows have to be dropped instead of advancing the run. The bench reaches it by starting a four-descriptor run and watching for the first start pulse. It then issues the zero write within the engine's latency, so the engine's done pulse arrives after the cancel. A fetch error is placed on a middle word of a descriptor so that the run stops part-way through the fetch.

// File: rtl/spi_desc_seq_pkg.sv
package spi_desc_seq_pkg;
  localparam int PTR_W      = 64;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 6;
  localparam int DESC_BYTES = DESC_WORDS * (WORD_W / 8);
  localparam int WIDX_W     = $clog2(DESC_WORDS);
  localparam int STS_W      = 12;

  localparam logic [7:0] OFF_OWN    = 8'h00;
  localparam logic [7:0] OFF_TRIG   = 8'h04;
  localparam logic [7:0] OFF_LIST_L = 8'h20;
  localparam logic [7:0] OFF_LIST_H = 8'h24;
  localparam logic [7:0] OFF_CUR_L  = 8'h28;
  localparam logic [7:0] OFF_CUR_H  = 8'h2C;
  localparam logic [7:0] OFF_STS    = 8'h30;
  localparam logic [7:0] OFF_IEN    = 8'h34;

  localparam int BIT_PENDING = 31;
  localparam int BIT_LAST    = 30;
  localparam int BIT_TRIG_RISE = 6;
  localparam int BIT_TRIG_FALL = 7;
  localparam int STS_DESC_ERR  = 8;
  localparam int STS_FREE      = 9;
  localparam int STS_DESC_DONE = 10;
  localparam int STS_RUN_DONE  = 11;

  typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_RUN} sq_state_e;

  function automatic logic [PTR_W-1:0] word_addr(input logic [PTR_W-1:0] base,
                                                 input logic [WIDX_W-1:0] idx);
    return base + PTR_W'({idx, 2'b00});
  endfunction

  function automatic logic [PTR_W-1:0] next_desc(input logic [PTR_W-1:0] base);
    return base + PTR_W'(DESC_BYTES);
  endfunction
endpackage

// File: rtl/seq_regs.sv
module seq_regs
  import spi_desc_seq_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              sync_in,
  input  logic              busy,
  input  logic [PTR_W-1:0]  cur_ptr,
  input  logic              evt_desc_done,
  input  logic              evt_run_done,
  input  logic              evt_fetch_err,
  output logic              start_req,
  output logic              abort_req,
  output logic [PTR_W-1:0]  start_ptr,
  output logic              irq
);
  logic              own_q;
  logic [WORD_W-1:0] trig_q, list_l_q, list_h_q;
  logic [STS_W-1:0]  sts_q, ien_q, sts_set, sts_clr;
  logic              sync_q, sync_rise, sync_fall, hw_start;
  logic              wr_own, wr_trig, wr_ll, wr_lh, wr_sts, wr_ien, sw_start;

  assign wr_own  = reg_wr && (reg_addr == REG_AW'(OFF_OWN));
  assign wr_trig = reg_wr && (reg_addr == REG_AW'(OFF_TRIG));
  assign wr_ll   = reg_wr && (reg_addr == REG_AW'(OFF_LIST_L));
  assign wr_lh   = reg_wr && (reg_addr == REG_AW'(OFF_LIST_H));
  assign wr_sts  = reg_wr && (reg_addr == REG_AW'(OFF_STS));
  assign wr_ien  = reg_wr && (reg_addr == REG_AW'(OFF_IEN));

  assign sync_rise = sync_in && !sync_q;
  assign sync_fall = !sync_in && sync_q;
  assign hw_start  = !busy && ((trig_q[BIT_TRIG_RISE] && sync_rise) ||
                               (trig_q[BIT_TRIG_FALL] && sync_fall));
  assign sw_start  = !busy && wr_lh && reg_wdata[BIT_PENDING];
  assign start_req = sw_start || hw_start;
  assign abort_req = busy && wr_lh && (reg_wdata == '0);
  assign start_ptr = sw_start ? {1'b0, reg_wdata[30:0], list_l_q}
                              : {1'b0, list_h_q[30:0], list_l_q};

  always_comb begin
    sts_set = '0;
    sts_set[STS_DESC_ERR]  = evt_fetch_err;
    sts_set[STS_FREE]      = evt_fetch_err || evt_run_done;
    sts_set[STS_DESC_DONE] = evt_desc_done;
    sts_set[STS_RUN_DONE]  = evt_run_done;
    sts_clr = wr_sts ? reg_wdata[STS_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= 1'b1;
      trig_q   <= '0;
      list_l_q <= '0;
      list_h_q <= '0;
      sts_q    <= '0;
      ien_q    <= '0;
      sync_q   <= 1'b0;
    end else begin
      sync_q <= sync_in;
      sts_q  <= (sts_q & ~sts_clr) | sts_set;
      if (wr_own)  own_q    <= reg_wdata[0];
      if (wr_trig) trig_q   <= reg_wdata;
      if (wr_ll)   list_l_q <= reg_wdata;
      if (wr_lh)   list_h_q <= reg_wdata;
      if (wr_ien)  ien_q    <= reg_wdata[STS_W-1:0];
    end
  end

  assign irq = |(sts_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_AW'(OFF_OWN):    reg_rdata = {31'd0, own_q};
      REG_AW'(OFF_TRIG):   reg_rdata = trig_q;
      REG_AW'(OFF_LIST_L): reg_rdata = list_l_q;
      REG_AW'(OFF_LIST_H): reg_rdata = {busy, list_h_q[30:0]};
      REG_AW'(OFF_CUR_L):  reg_rdata = cur_ptr[31:0];
      REG_AW'(OFF_CUR_H):  reg_rdata = cur_ptr[63:32];
      REG_AW'(OFF_STS):    reg_rdata = WORD_W'(sts_q);
      REG_AW'(OFF_IEN):    reg_rdata = WORD_W'(ien_q);
      default:             reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/seq_fetch.sv
module seq_fetch
  import spi_desc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              abort_req,
  input  logic [PTR_W-1:0]  start_ptr,
  output logic              mem_req,
  output logic [PTR_W-1:0]  mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rerr,
  output logic              eng_start,
  output logic [WORD_W-1:0] eng_cfg,
  output logic [WORD_W-1:0] eng_bus,
  output logic [PTR_W-1:0]  eng_tx_addr,
  output logic [PTR_W-1:0]  eng_rx_addr,
  input  logic              eng_done,
  output logic              busy,
  output logic [PTR_W-1:0]  cur_ptr,
  output logic              evt_desc_done,
  output logic              evt_run_done,
  output logic              evt_fetch_err,
  output logic              evt_abort,
  output logic              evt_advance
);
  sq_state_e          state_q;
  logic [PTR_W-1:0]   base_q;
  logic [WIDX_W-1:0]  widx_q;
  logic [WORD_W-1:0]  dword_q [DESC_WORDS];
  logic               take_word, last_word;

  assign busy      = (state_q != SQ_IDLE);
  assign mem_req   = (state_q == SQ_FETCH);
  assign mem_addr  = word_addr(base_q, widx_q);
  assign cur_ptr   = base_q;
  assign evt_abort = busy && abort_req;
  assign take_word = mem_req && mem_rvalid && !mem_rerr && !abort_req;
  assign last_word = (widx_q == WIDX_W'(DESC_WORDS - 1));

  assign evt_fetch_err = mem_req && mem_rvalid && mem_rerr && !abort_req;
  assign evt_desc_done = (state_q == SQ_RUN) && eng_done && !abort_req;
  assign evt_run_done  = evt_desc_done && dword_q[0][BIT_LAST];
  assign evt_advance   = evt_desc_done && !dword_q[0][BIT_LAST];

  generate
    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      dword_q[g] <= '0;
        else if (take_word && widx_q == WIDX_W'(g))      dword_q[g] <= mem_rdata;
      end
    end
  endgenerate

  assign eng_cfg     = dword_q[0];
  assign eng_bus     = dword_q[1];
  assign eng_tx_addr = {dword_q[3], dword_q[2]};
  assign eng_rx_addr = {dword_q[5], dword_q[4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      base_q    <= '0;
      widx_q    <= '0;
      eng_start <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      case (state_q)
        SQ_IDLE: if (start_req) begin
          base_q  <= start_ptr;
          widx_q  <= '0;
          state_q <= SQ_FETCH;
        end
        SQ_FETCH: begin
          if (evt_abort || evt_fetch_err) begin
            state_q <= SQ_IDLE;
          end else if (take_word) begin
            if (last_word) begin
              state_q   <= SQ_RUN;
              eng_start <= 1'b1;
            end else begin
              widx_q <= widx_q + 1'b1;
            end
          end
        end
        SQ_RUN: begin
          if (evt_abort || evt_run_done) begin
            state_q <= SQ_IDLE;
          end else if (evt_advance) begin
            base_q  <= next_desc(base_q);
            widx_q  <= '0;
            state_q <= SQ_FETCH;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_desc_chain_seq.sv
module spi_desc_chain_seq
  import spi_desc_seq_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              sync_in,
  output logic              mem_req,
  output logic [63:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rerr,
  output logic              eng_start,
  output logic [31:0]       eng_cfg,
  output logic [31:0]       eng_bus,
  output logic [63:0]       eng_tx_addr,
  output logic [63:0]       eng_rx_addr,
  input  logic              eng_done,
  output logic              irq
);
  logic             busy_w, start_req_w, abort_req_w;
  logic [PTR_W-1:0] start_ptr_w, cur_ptr_w;
  logic             evt_desc_done, evt_run_done, evt_fetch_err, evt_abort, evt_advance;

  seq_regs #(.REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sync_in(sync_in),
    .busy(busy_w), .cur_ptr(cur_ptr_w), .evt_desc_done(evt_desc_done),
    .evt_run_done(evt_run_done), .evt_fetch_err(evt_fetch_err),
    .start_req(start_req_w), .abort_req(abort_req_w),
    .start_ptr(start_ptr_w), .irq(irq)
  );

  seq_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .start_req(start_req_w), .abort_req(abort_req_w),
    .start_ptr(start_ptr_w), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
    .eng_start(eng_start), .eng_cfg(eng_cfg), .eng_bus(eng_bus),
    .eng_tx_addr(eng_tx_addr), .eng_rx_addr(eng_rx_addr), .eng_done(eng_done),
    .busy(busy_w), .cur_ptr(cur_ptr_w), .evt_desc_done(evt_desc_done),
    .evt_run_done(evt_run_done), .evt_fetch_err(evt_fetch_err),
    .evt_abort(evt_abort), .evt_advance(evt_advance)
  );
endmodule

// File: rtl/seq_chk.sv
module seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        eng_start,
  input logic        mem_req,
  input logic        busy,
  input logic        evt_fetch_err,
  input logic        evt_run_done,
  input logic        evt_abort,
  input logic        evt_advance,
  input logic [63:0] cur_ptr
);
  a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  a_r7_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fetch_err |=> (!busy && !eng_start));
  a_r5_last_stops: assert property (@(posedge clk) disable iff (!rst_n)
    evt_run_done |=> (!busy && !mem_req));
  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abort |=> (!mem_req && !eng_start));
  a_r4_step_24: assert property (@(posedge clk) disable iff (!rst_n)
    evt_advance |=> (cur_ptr == $past(cur_ptr) + 64'd24));
  a_r2_fetch_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);
endmodule

bind spi_desc_chain_seq seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .mem_req(mem_req),
  .busy(busy_w), .evt_fetch_err(evt_fetch_err), .evt_run_done(evt_run_done),
  .evt_abort(evt_abort), .evt_advance(evt_advance), .cur_ptr(cur_ptr_w)
);

// File: tb/spi_desc_chain_seq_test.sv
module spi_desc_chain_seq_test;
  localparam int ENG_LAT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sync_in = 1'b0;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_rerr = 1'b0;
  logic        eng_start;
  logic [31:0] eng_cfg, eng_bus;
  logic [63:0] eng_tx_addr, eng_rx_addr;
  logic        eng_done = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int n_start = 0;
  int eng_cnt = 0;
  logic [31:0]  mem [0:1023];
  logic [63:0]  err_addr = 64'hFFFF_FFFF_FFFF_FFFF;
  logic [191:0] exp_q [$];

  always #2 clk = ~clk;

  spi_desc_chain_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sync_in(sync_in),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .eng_start(eng_start),
    .eng_cfg(eng_cfg), .eng_bus(eng_bus), .eng_tx_addr(eng_tx_addr),
    .eng_rx_addr(eng_rx_addr), .eng_done(eng_done), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder and engine model, driven at the falling edge
  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      mem_rerr   = 1'b0;
    end else if (mem_req) begin
      mem_rvalid = 1'b1;
      mem_rdata  = mem[mem_addr[11:2]];
      mem_rerr   = (mem_addr == err_addr);
    end
    eng_done = 1'b0;
    if (eng_start) begin
      eng_cnt = ENG_LAT;
    end else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) eng_done = 1'b1;
    end
  end

  // per-clock comparison of the engine hand-off against the expected queue
  always @(negedge clk) begin
    if (rst_n && eng_start) begin
      n_start++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected eng_start", 192'd1, 192'd0);
      end else begin
        logic [191:0] e;
        e = exp_q.pop_front();
        check({eng_cfg, eng_bus, eng_tx_addr, eng_rx_addr} == e, "R3 descriptor fields",
              {eng_cfg, eng_bus, eng_tx_addr, eng_rx_addr}, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(input int base, input bit last, input int seed, input bit expect_it);
    logic [31:0] w [6];
    w[0] = (last ? 32'h4000_0000 : 32'h0) | 32'(seed);
    w[1] = 32'hB000_0000 | 32'(seed);
    w[2] = 32'h1000_0000 + 32'(seed);
    w[3] = 32'h0000_00A0 + 32'(seed);
    w[4] = 32'h2000_0000 + 32'(seed);
    w[5] = 32'h0000_00C0 + 32'(seed);
    for (int i = 0; i < 6; i++) mem[(base >> 2) + i] = w[i];
    if (expect_it) exp_q.push_back({w[0], w[1], w[3], w[2], w[5], w[4]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(8'h00, v); check(v == 1, "R1 ownership flag", v, 1);
    rd(8'h30, v); check(v == 0, "R1 status", v, 0);
    check(!irq && !mem_req, "R1 irq/mem_req idle", {irq, mem_req}, 0);

    // R11: ownership flag
    wr(8'h00, 0); rd(8'h00, v); check(v == 0, "R11 claim", v, 0);
    wr(8'h00, 1); rd(8'h00, v); check(v == 1, "R11 release", v, 1);

    // R2 R3 R4 R5 R6: three-descriptor run
    put_desc(32'h100, 0, 1, 1);
    put_desc(32'h118, 0, 2, 1);
    put_desc(32'h130, 1, 3, 1);
    wr(8'h34, 32'h800);
    wr(8'h20, 32'h100);
    s0 = n_start;
    wr(8'h24, 32'h8000_0000);
    rd(8'h24, v); check(v[31] == 1, "R2 pending reads busy", v, 32'h8000_0000);
    wait (n_start == s0 + 2);
    rd(8'h28, v); check(v == 32'h118, "R4 current pointer second descriptor", v, 32'h118);
    rd(8'h2C, v); check(v == 0, "R4 current pointer high", v, 0);
    repeat (150) @(posedge clk);
    check(n_start == s0 + 3, "R4 three descriptors executed", n_start - s0, 3);
    rd(8'h30, v); check(v == 32'hE00, "R5 R6 status after run", v, 32'hE00);
    rd(8'h24, v); check(v[31] == 0, "R5 pending cleared", v[31], 0);
    check(irq == 1, "R10 irq with enabled run-done", irq, 1);
    wr(8'h30, 32'h800); rd(8'h30, v); check(v == 32'h600, "R10 w1c", v, 32'h600);
    check(irq == 0, "R10 irq after clear", irq, 0);
    wr(8'h30, 32'hFFF);

    // R7: fetch error on third word
    put_desc(32'h200, 1, 4, 0);
    err_addr = 64'h208;
    s0 = n_start;
    wr(8'h34, 32'h800);
    wr(8'h20, 32'h200);
    wr(8'h24, 32'h8000_0000);
    repeat (60) @(posedge clk);
    check(n_start == s0, "R7 no eng_start after error", n_start - s0, 0);
    rd(8'h30, v); check(v == 32'h300, "R7 status error+free", v, 32'h300);
    check(!mem_req, "R7 fetch halted", mem_req, 0);
    check(irq == 0, "R10 masked status keeps irq low", irq, 0);
    wr(8'h34, 32'h100); @(negedge clk);
    check(irq == 1, "R10 irq on enabled error", irq, 1);
    wr(8'h30, 32'hFFF);
    err_addr = 64'hFFFF_FFFF_FFFF_FFFF;

    // R8: hardware trigger edges
    put_desc(32'h300, 1, 5, 1);
    wr(8'h20, 32'h300);
    wr(8'h24, 32'h0);
    wr(8'h04, 32'h40);
    s0 = n_start;
    @(negedge clk) sync_in = 1'b1;
    repeat (80) @(posedge clk);
    check(n_start == s0 + 1, "R8 rising edge start", n_start - s0, 1);
    rd(8'h30, v); check(v[11] == 1, "R8 run done after rising trigger", v, 32'h800);
    wr(8'h30, 32'hFFF);
    put_desc(32'h300, 1, 5, 1);
    wr(8'h04, 32'h80);
    @(negedge clk) sync_in = 1'b0;
    repeat (80) @(posedge clk);
    check(n_start == s0 + 2, "R8 falling edge start", n_start - s0, 2);
    wr(8'h04, 32'h0);
    @(negedge clk) sync_in = 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk) sync_in = 1'b0;
    repeat (40) @(posedge clk);
    check(n_start == s0 + 2, "R8 edges ignored when disabled", n_start - s0, 2);
    wr(8'h30, 32'hFFF);

    // R9: cancel during engine run
    put_desc(32'h400, 0, 6, 1);
    put_desc(32'h418, 0, 7, 0);
    put_desc(32'h430, 0, 8, 0);
    put_desc(32'h448, 1, 9, 0);
    wr(8'h34, 32'hFFF);
    wr(8'h20, 32'h400);
    s0 = n_start;
    wr(8'h24, 32'h8000_0000);
    wait (n_start == s0 + 1);
    wr(8'h24, 32'h0);
    repeat (100) @(posedge clk);
    check(n_start == s0 + 1, "R9 no start after cancel", n_start - s0, 1);
    check(!mem_req, "R9 no fetch after cancel", mem_req, 0);
    rd(8'h30, v); check(v == 0, "R9 no status from cancelled run", v, 0);
    check(irq == 0, "R9 irq low after cancel", irq, 0);
    rd(8'h24, v); check(v[31] == 0, "R9 idle after cancel", v, 0);
    exp_q.delete();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule